// File: doc/BRIEF.md
# Serial Port Host Register and FIFO Interface

This block sits between a processor bus and the serial frame engine of a synchronous serial port. It holds the configuration that the engine uses, buffers outgoing and incoming frames in two eight-entry queues, reports queue state through a status word, and raises one interrupt line built from three maskable sources: receive queue filling, transmit queue draining, and a receive overrun.

Software reaches six word-indexed registers through a simple single-cycle bus: select, write strobe, word index, write data and combinational read data. A write to the data register queues a frame for transmission. A read of the data register returns and removes the oldest received frame. The frame engine takes transmit frames through a valid/ready pop port. It delivers receive frames through a push port that cannot stall: when the receive queue is full, the arriving frame is dropped and the overrun flag is set. Software clears that flag by writing any value to the interrupt register.

Top module: `sport_host_if`

## Requirements
- R1: After reset, control 0, control 1 and prescale read 0, status reads 0x03, interrupt status reads 0x02, and `irq` and `txq_valid` are low.
- R2: Word 0 (control 0, all DATA_W bits), word 1 (control 1, bits 6:0) and word 4 (prescale, low 8 bits) store what is written and read it back, with unused upper bits reading 0. The stored values drive `cfg_frame` and `cfg_psc`. Control 1 bit 3 drives `cfg_loopback`, bit 4 drives `cfg_enable`, bit 5 drives `cfg_slave` and bit 6 drives `cfg_slave_odis`.
- R3: A write to word 2 queues a transmit frame. Up to 8 frames leave on `txq_data` in write order. A write made while 8 frames are held at the start of that cycle is discarded.
- R4: `txq_valid` is high only while control 1 bit 4 is 1 and the transmit queue is not empty. Each cycle with `txq_valid` and `txq_ready` both high removes one frame.
- R5: A frame on the push port is stored when `rxq_valid` is high and fewer than 8 frames are held. A read of word 2 returns the oldest frame and removes it. A push and a pop in the same cycle both take effect.
- R6: A read of word 2 while the receive queue is empty returns 0 and leaves the queue unchanged, so the next pushed frame is the next one read.
- R7: Word 3 reads the status: bit 0 transmit empty, bit 1 transmit not full, bit 2 receive not empty, bit 3 receive full, bit 4 busy (`eng_busy` high or transmit queue not empty). Writes to word 3 have no effect.
- R8: Word 5 reads the interrupt status: bit 0 is set while the receive queue holds 4 or more frames, bit 1 while the transmit queue holds 4 or fewer, and bit 2 is the overrun flag.
- R9: When `rxq_valid` is high while 8 receive frames are held at the start of the cycle, the frame is dropped and the overrun flag sets. `rxq_ready` is low while the receive queue is full.
- R10: Any write to word 5 clears the overrun flag. An overrun arriving in the same cycle as that write leaves the flag set.
- R11: `irq` is high exactly when any interrupt status bit n (n = 0, 1, 2) is set together with control 1 bit n.
- R12: Words 6 and 7 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_widx | input | 3 | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the indexed word (combinational) |
| txq_valid | output | 1 | Transmit frame available to the engine |
| txq_data | output | DATA_W | Oldest transmit frame |
| txq_ready | input | 1 | Engine takes the transmit frame |
| rxq_valid | input | 1 | Engine delivers a received frame |
| rxq_data | input | DATA_W | Received frame |
| rxq_ready | output | 1 | Receive queue has room |
| eng_busy | input | 1 | Engine is shifting a frame |
| cfg_frame | output | DATA_W | Control 0 contents |
| cfg_psc | output | PSC_W | Prescale contents |
| cfg_loopback | output | 1 | Loopback select |
| cfg_enable | output | 1 | Port enable |
| cfg_slave | output | 1 | Slave mode select |
| cfg_slave_odis | output | 1 | Slave output disable |
| irq | output | 1 | Combined interrupt |

## Verification
Two pairs of actions can land in the same cycle. The first is an engine push into a partly filled receive queue together with a bus read of the data word. The bench drives both in one cycle and expects the oldest frame on the read, followed by the remaining frames and the new one in order. The second is an overrun arrival together with a software clear of the overrun flag. The bench fills the receive queue, forces a push into the full queue in the same cycle as a write to word 5, and expects the flag to stay set until a later lone clear removes it.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int WIDX_W = 3;
    localparam int STAT_W = 5;
    localparam int CTL1_W = 7;
    localparam int IRQ_N  = 3;

    typedef enum logic [WIDX_W-1:0] {
        W_CTL0 = 3'd0,
        W_CTL1 = 3'd1,
        W_DATA = 3'd2,
        W_STAT = 3'd3,
        W_PSC  = 3'd4,
        W_INTR = 3'd5,
        W_RSV6 = 3'd6,
        W_RSV7 = 3'd7
    } widx_e;

    // Control 1 layout, bit 0 at the bottom
    typedef struct packed {
        logic slv_odis;
        logic slave;
        logic port_en;
        logic loopback;
        logic ror_ie;
        logic tx_ie;
        logic rx_ie;
    } ctl1_t;

    typedef struct packed {
        logic busy;
        logic rx_full;
        logic rx_nempty;
        logic tx_nfull;
        logic tx_empty;
    } stat_t;

    typedef struct packed {
        logic ror;
        logic tx_req;
        logic rx_req;
    } irq_vec_t;

    function automatic logic [IRQ_N-1:0] ctl1_enables(input ctl1_t c);
        return {c.ror_ie, c.tx_ie, c.rx_ie};
    endfunction

endpackage

// File: rtl/sport_fifo.sv
module sport_fifo #(
    parameter  int WIDTH = 16,
    parameter  int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [PTR_W-1:0]            wr_ptr;
    logic [PTR_W-1:0]            rd_ptr;
    logic                        do_push;
    logic                        do_pop;
    logic [DEPTH-1:0][WIDTH-1:0] tapped;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // One storage slot per entry; each offers its word only when selected
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [WIDTH-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (do_push && (wr_ptr == PTR_W'(i))) begin
                q <= push_data;
            end
        end
        assign tapped[i] = (rd_ptr == PTR_W'(i)) ? q : '0;
    end

    always_comb begin
        head = '0;
        for (int i = 0; i < DEPTH; i++) begin
            head = head | tapped[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= advance(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= advance(rd_ptr);
            end
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    AST_FIFO_GROW: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> (count == $past(count) + CNT_W'(1))); // R3

    AST_FIFO_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty); // R6

endmodule

// File: rtl/sport_irq.sv
module sport_irq
    import sport_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int HALF  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             ovr_event,
    input  logic             ovr_clear,
    input  logic [IRQ_N-1:0] enables,
    output irq_vec_t         raw,
    output logic             irq
);

    localparam logic [CNT_W-1:0] MARK = CNT_W'(HALF);

    logic ror_q;

    // A new overrun in the clearing cycle wins over the clear
    always_ff @(posedge clk) begin
        if (rst) begin
            ror_q <= 1'b0;
        end else if (ovr_event) begin
            ror_q <= 1'b1;
        end else if (ovr_clear) begin
            ror_q <= 1'b0;
        end
    end

    always_comb begin
        raw.rx_req = (rx_count >= MARK);
        raw.tx_req = (tx_count <= MARK);
        raw.ror    = ror_q;
    end

    assign irq = |(raw & enables);

    AST_ROR_SET: assert property (@(posedge clk) disable iff (rst)
        ovr_event |=> raw.ror); // R9

    AST_ROR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ovr_clear && !ovr_event) |=> !raw.ror); // R10

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (enables == '0) |-> !irq); // R11

endmodule

// File: rtl/sport_host_if.sv
module sport_host_if
    import sport_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int PSC_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [WIDX_W-1:0] bus_widx,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              txq_valid,
    output logic [DATA_W-1:0] txq_data,
    input  logic              txq_ready,
    input  logic              rxq_valid,
    input  logic [DATA_W-1:0] rxq_data,
    output logic              rxq_ready,
    input  logic              eng_busy,
    output logic [DATA_W-1:0] cfg_frame,
    output logic [PSC_W-1:0]  cfg_psc,
    output logic              cfg_loopback,
    output logic              cfg_enable,
    output logic              cfg_slave,
    output logic              cfg_slave_odis,
    output logic              irq
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam int HALF  = FIFO_DEPTH / 2;

    widx_e             idx;
    logic              wr_hit;
    logic              rd_hit;
    logic [DATA_W-1:0] ctl0_q;
    ctl1_t             ctl1_q;
    logic [PSC_W-1:0]  psc_q;

    logic              tx_wr;
    logic              tx_take;
    logic [CNT_W-1:0]  tx_count;
    logic              tx_empty;
    logic              tx_full;

    logic              rx_rd;
    logic [DATA_W-1:0] rx_head;
    logic [CNT_W-1:0]  rx_count;
    logic              rx_empty;
    logic              rx_full;

    logic              ovr_event;
    logic              ovr_clear;
    irq_vec_t          irq_raw;
    stat_t             stat;

    // Bus decode
    assign idx       = widx_e'(bus_widx);
    assign wr_hit    = bus_sel && bus_wr;
    assign rd_hit    = bus_sel && !bus_wr;
    assign tx_wr     = wr_hit && (idx == W_DATA);
    assign rx_rd     = rd_hit && (idx == W_DATA);
    assign ovr_clear = wr_hit && (idx == W_INTR);

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl0_q <= '0;
            ctl1_q <= '0;
            psc_q  <= '0;
        end else if (wr_hit) begin
            case (idx)
                W_CTL0:  ctl0_q <= bus_wdata;
                W_CTL1:  ctl1_q <= ctl1_t'(bus_wdata[CTL1_W-1:0]);
                W_PSC:   psc_q  <= bus_wdata[PSC_W-1:0];
                default: ;
            endcase
        end
    end

    assign cfg_frame      = ctl0_q;
    assign cfg_psc        = psc_q;
    assign cfg_loopback   = ctl1_q.loopback;
    assign cfg_enable     = ctl1_q.port_en;
    assign cfg_slave      = ctl1_q.slave;
    assign cfg_slave_odis = ctl1_q.slv_odis;

    // Transmit queue: bus pushes, engine pops
    assign txq_valid = ctl1_q.port_en && !tx_empty;
    assign tx_take   = txq_valid && txq_ready;

    sport_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_txq (
        .clk       (clk),
        .rst       (rst),
        .push      (tx_wr),
        .push_data (bus_wdata),
        .pop       (tx_take),
        .head      (txq_data),
        .count     (tx_count),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    // Receive queue: engine pushes without stalling, bus pops
    assign rxq_ready = !rx_full;
    assign ovr_event = rxq_valid && rx_full;

    sport_fifo #(
        .WIDTH (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (rxq_valid),
        .push_data (rxq_data),
        .pop       (rx_rd),
        .head      (rx_head),
        .count     (rx_count),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    sport_irq #(
        .CNT_W (CNT_W),
        .HALF  (HALF)
    ) u_irq (
        .clk       (clk),
        .rst       (rst),
        .tx_count  (tx_count),
        .rx_count  (rx_count),
        .ovr_event (ovr_event),
        .ovr_clear (ovr_clear),
        .enables   (ctl1_enables(ctl1_q)),
        .raw       (irq_raw),
        .irq       (irq)
    );

    // Status word
    always_comb begin
        stat.tx_empty  = tx_empty;
        stat.tx_nfull  = !tx_full;
        stat.rx_nempty = !rx_empty;
        stat.rx_full   = rx_full;
        stat.busy      = eng_busy || !tx_empty;
    end

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (idx)
            W_CTL0:  bus_rdata = ctl0_q;
            W_CTL1:  bus_rdata = {{(DATA_W-CTL1_W){1'b0}}, ctl1_q};
            W_DATA:  bus_rdata = rx_empty ? '0 : rx_head;
            W_STAT:  bus_rdata = {{(DATA_W-STAT_W){1'b0}}, stat};
            W_PSC:   bus_rdata = {{(DATA_W-PSC_W){1'b0}}, psc_q};
            W_INTR:  bus_rdata = {{(DATA_W-IRQ_N){1'b0}}, irq_raw};
            default: bus_rdata = '0;
        endcase
    end

    AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (rst)
        (tx_full && tx_wr && !tx_take) |=> tx_full); // R3

    AST_RX_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rx_full && rxq_valid && !rx_rd) |=> (rx_full && !rxq_ready)); // R9

    AST_RX_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (rx_rd && rx_empty) |-> (bus_rdata == '0)); // R6

    AST_TX_ORDER_HOLD: assert property (@(posedge clk) disable iff (rst)
        (txq_valid && !txq_ready && ctl1_q.port_en) |=> $stable(txq_data)); // R4

endmodule

// File: tb/sport_host_if_tb.sv
module sport_host_if_tb;
    import sport_pkg::*;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_widx = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          txq_valid;
    logic [DW-1:0] txq_data;
    logic          txq_ready = 1'b0;
    logic          rxq_valid = 1'b0;
    logic [DW-1:0] rxq_data = '0;
    logic          rxq_ready;
    logic          eng_busy = 1'b0;
    logic [DW-1:0] cfg_frame;
    logic [7:0]    cfg_psc;
    logic          cfg_loopback, cfg_enable, cfg_slave, cfg_slave_odis;
    logic          irq;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    sport_host_if u_dut (
        .clk            (clk),
        .rst            (rst),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_widx       (bus_widx),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .txq_valid      (txq_valid),
        .txq_data       (txq_data),
        .txq_ready      (txq_ready),
        .rxq_valid      (rxq_valid),
        .rxq_data       (rxq_data),
        .rxq_ready      (rxq_ready),
        .eng_busy       (eng_busy),
        .cfg_frame      (cfg_frame),
        .cfg_psc        (cfg_psc),
        .cfg_loopback   (cfg_loopback),
        .cfg_enable     (cfg_enable),
        .cfg_slave      (cfg_slave),
        .cfg_slave_odis (cfg_slave_odis),
        .irq            (irq)
    );

    // {write, word index, data or expected read value}
    localparam int NV = 13;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 3'd0, 16'hA5C3},
        {1'b0, 3'd0, 16'hA5C3},
        {1'b1, 3'd1, 16'h00FF},
        {1'b0, 3'd1, 16'h007F},
        {1'b1, 3'd4, 16'h1234},
        {1'b0, 3'd4, 16'h0034},
        {1'b1, 3'd3, 16'hFFFF},
        {1'b0, 3'd3, 16'h0003},
        {1'b1, 3'd6, 16'h5555},
        {1'b0, 3'd6, 16'h0000},
        {1'b0, 3'd7, 16'h0000},
        {1'b1, 3'd1, 16'h0048},
        {1'b0, 3'd1, 16'h0048}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] w, input logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        #1;
    endtask

    task automatic bus_read(input logic [2:0] w, output logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = w;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
        #1;
    endtask

    task automatic rx_push(input logic [DW-1:0] d);
        @(negedge clk);
        rxq_valid = 1'b1; rxq_data = d;
        @(negedge clk);
        rxq_valid = 1'b0;
        #1;
    endtask

    function automatic string vec_tag(input logic [2:0] w);
        case (w)
            3'd3:       return "R7 status write ignored";
            3'd6, 3'd7: return "R12 unmapped word";
            default:    return "R2 register readback";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        bus_read(3'd0, rd); check("R1 ctl0 reset", rd, 16'h0000);
        bus_read(3'd1, rd); check("R1 ctl1 reset", rd, 16'h0000);
        bus_read(3'd4, rd); check("R1 prescale reset", rd, 16'h0000);
        bus_read(3'd3, rd); check("R1 status reset", rd, 16'h0003);
        bus_read(3'd5, rd); check("R1 interrupt status reset", rd, 16'h0002);
        check("R1 irq reset", irq, 1'b0);
        check("R1 txq_valid reset", txq_valid, 1'b0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][19]) begin
                bus_write(VEC[i][18:16], VEC[i][15:0]);
            end else begin
                bus_read(VEC[i][18:16], rd);
                check(vec_tag(VEC[i][18:16]), rd, VEC[i][15:0]);
            end
        end
        check("R2 cfg_frame", cfg_frame, 16'hA5C3);
        check("R2 cfg_psc", cfg_psc, 8'h34);
        check("R2 cfg flags", {cfg_slave_odis, cfg_slave, cfg_enable, cfg_loopback}, 4'b1001);

        // R3 / R4 transmit queue, port disabled
        bus_write(3'd1, 16'h0000);
        for (int i = 0; i < 9; i++) bus_write(3'd2, 16'h0100 + 16'(i));
        check("R4 txq_valid gated by disable", txq_valid, 1'b0);
        bus_read(3'd3, rd); check("R7 status tx full busy", rd, 16'h0010);
        bus_read(3'd5, rd); check("R8 tx request off at 8", rd, 16'h0000);
        bus_write(3'd1, 16'h0010);
        check("R4 txq_valid after enable", txq_valid, 1'b1);
        @(negedge clk);
        txq_ready = 1'b1;
        for (int i = 0; i < 8; i++) begin
            #1;
            check("R3 tx order", {txq_valid, txq_data}, {1'b1, 16'h0100 + 16'(i)});
            @(negedge clk);
        end
        txq_ready = 1'b0;
        #1 check("R3 ninth write dropped", txq_valid, 1'b0);

        // R8 transmit threshold and R11 mask
        for (int i = 0; i < 5; i++) bus_write(3'd2, 16'h0200 + 16'(i));
        bus_read(3'd5, rd); check("R8 tx request off at 5", rd, 16'h0000);
        @(negedge clk); txq_ready = 1'b1;
        @(negedge clk); txq_ready = 1'b0;
        bus_read(3'd5, rd); check("R8 tx request on at 4", rd, 16'h0002);
        bus_write(3'd1, 16'h0012);
        check("R11 irq tx enabled", irq, 1'b1);
        bus_write(3'd1, 16'h0010);
        check("R11 irq tx masked", irq, 1'b0);
        @(negedge clk); txq_ready = 1'b1;
        repeat (4) @(negedge clk);
        txq_ready = 1'b0;
        bus_read(3'd3, rd); check("R7 status tx drained", rd, 16'h0003);

        // R5 / R8 receive queue
        bus_write(3'd1, 16'h0000);
        for (int i = 0; i < 3; i++) rx_push(16'h0300 + 16'(i));
        bus_read(3'd5, rd); check("R8 rx request off at 3", rd, 16'h0002);
        rx_push(16'h0303);
        bus_read(3'd5, rd); check("R8 rx request on at 4", rd, 16'h0003);
        bus_read(3'd3, rd); check("R7 status rx not empty", rd, 16'h0007);
        for (int i = 0; i < 4; i++) begin
            bus_read(3'd2, rd); check("R5 rx order", rd, 16'h0300 + 16'(i));
        end

        // R6 empty read
        bus_read(3'd2, rd); check("R6 empty read zero", rd, 16'h0000);
        bus_read(3'd3, rd); check("R6 status after empty read", rd, 16'h0003);
        rx_push(16'hBEEF);
        bus_read(3'd2, rd); check("R6 next frame after empty read", rd, 16'hBEEF);

        // R5 push and pop in the same cycle
        rx_push(16'h00A1);
        rx_push(16'h00A2);
        @(negedge clk);
        rxq_valid = 1'b1; rxq_data = 16'h00A3;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_widx = 3'd2;
        #1 rd = bus_rdata;
        check("R5 concurrent pop returns oldest", rd, 16'h00A1);
        @(negedge clk);
        rxq_valid = 1'b0; bus_sel = 1'b0;
        bus_read(3'd2, rd); check("R5 concurrent second", rd, 16'h00A2);
        bus_read(3'd2, rd); check("R5 concurrent pushed frame kept", rd, 16'h00A3);
        bus_read(3'd3, rd); check("R5 queue empty after", rd, 16'h0003);

        // R9 / R10 / R11 overrun
        bus_write(3'd1, 16'h0014);
        for (int i = 0; i < 8; i++) rx_push(16'h0400 + 16'(i));
        check("R9 rxq_ready low when full", rxq_ready, 1'b0);
        bus_read(3'd3, rd); check("R7 status rx full", rd, 16'h000F);
        bus_read(3'd5, rd); check("R8 full no overrun", rd, 16'h0003);
        check("R11 irq ror masked clear", irq, 1'b0);
        rx_push(16'hDEAD);
        bus_read(3'd5, rd); check("R9 overrun flagged", rd, 16'h0007);
        check("R11 irq on overrun", irq, 1'b1);
        for (int i = 0; i < 8; i++) begin
            bus_read(3'd2, rd); check("R9 overrun frame dropped", rd, 16'h0400 + 16'(i));
        end
        bus_read(3'd5, rd); check("R9 overrun sticky", rd, 16'h0006);
        bus_write(3'd5, 16'h0000);
        bus_read(3'd5, rd); check("R10 clear by write", rd, 16'h0002);
        check("R11 irq after clear", irq, 1'b0);

        // R10 overrun and clear in the same cycle
        for (int i = 0; i < 8; i++) rx_push(16'h0500 + 16'(i));
        rx_push(16'h05FF);
        @(negedge clk);
        rxq_valid = 1'b1; rxq_data = 16'h05FE;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_widx = 3'd5; bus_wdata = 16'hFFFF;
        @(negedge clk);
        rxq_valid = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_read(3'd5, rd); check("R10 set wins over clear", rd, 16'h0007);
        bus_write(3'd5, 16'h0001);
        bus_read(3'd5, rd); check("R10 lone clear", rd, 16'h0003);
        for (int i = 0; i < 8; i++) begin
            bus_read(3'd2, rd); check("R9 drain after overrun", rd, 16'h0500 + 16'(i));
        end

        // R7 engine busy
        eng_busy = 1'b1;
        bus_read(3'd3, rd); check("R7 busy from engine", rd, 16'h0013);
        eng_busy = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule